// File: doc/BRIEF.md
# Buffered Full-Duplex SPI Master

This block drives an SPI bus from a local byte array. A host fills the array through a simple write port, sets a configuration byte, and then starts a transfer with a byte count and a four-bit mask of slave-select lines. The master then works through the array from location zero. It shifts each byte out on MOSI and captures the byte that arrives on MISO at the same time. The captured byte replaces the transmitted byte at the same location, so once the transfer is over the host reads the slave's reply from the same addresses it wrote.

Clock polarity, clock phase, bit order and one of four clock rates come from the configuration byte. The mask may enable any combination of the four select lines, and all of them are driven together. When a transfer ends, an active-low interrupt latches and stays low until the host clears it. A busy flag covers the whole transfer. While busy is high, the block ignores new start requests, configuration writes and host writes to the array.

Top module: `spi_buf_master`

## Requirements
- R1: After reset, irq_n is 1, busy is 0, all four ss_n lines are 1, sclk is 0, and the configuration byte is zero.
- R2: In the configuration byte, bit 5 selects the bit order (0 = MSB first, 1 = LSB first) and bits 3:2 select the mode as {CPOL,CPHA}. Bits 1:0 select the rate. Bits 7:6 and bit 4 have no effect.
- R3: Rate codes 0, 1, 2 and 3 give an SCLK period of 4, 16, 64 and 128 clocks. With half period h and a count of n bytes, busy stays high for exactly h*(16n+1) clocks, and the transfer makes exactly 16n SCLK edges.
- R4: While busy is high, ss_n equals the bitwise inverse of the mask captured at start, with any combination allowed, and it holds that value for the whole transfer. While idle, ss_n is 4'hF.
- R5: The selected lines go low one half period before the first SCLK edge and return high one half period after the last SCLK edge.
- R6: Bytes 0 to n-1 of the array are sent on MOSI in order, each in the configured bit order. With CPHA=0 the slave samples on leading edges, and with CPHA=1 it samples on trailing edges.
- R7: Each byte sampled from MISO is written to the array location of the byte sent alongside it, and the host can read it on buf_rdata.
- R8: irq_n goes low in the same cycle that busy falls. It stays low until clr_irq is pulsed, and then it is high in the next cycle.
- R9: A start pulse is ignored while busy, and also when xfer_len is 0 or greater than DEPTH (200).
- R10: While idle, sclk equals CPOL. While busy, cfg_we and buf_we have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Asynchronous reset, active high |
| cfg_we | input | 1 | Write strobe for the configuration byte |
| cfg_data | input | 8 | Configuration byte value |
| start | input | 1 | Start request |
| sel_mask | input | 4 | Slave-select mask, bit i drives ss_n[i] |
| xfer_len | input | 8 | Byte count, 1 to DEPTH |
| clr_irq | input | 1 | Clears the interrupt |
| buf_we | input | 1 | Host write strobe to the byte array |
| buf_addr | input | 8 | Host address into the byte array |
| buf_wdata | input | 8 | Host write data |
| buf_rdata | output | 8 | Array contents at buf_addr (combinational) |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 4 | Active-low slave selects |
| irq_n | output | 1 | Active-low transfer-done interrupt |
| busy | output | 1 | High during a transfer |

## Verification
When start is accepted at a rising edge, busy and the selects change at that same edge. Every later event is a whole number of half periods h after that edge: the first SCLK edge comes h clocks later, busy falls and irq_n drops h*(16n+1) clocks later, and the selects release h clocks after the last edge. Because clr_irq is registered, it takes effect at the next edge. The bench drives inputs and samples outputs on the falling clock edge, so it reads each result half a clock after the rising edge that produced it. It time-stamps select and SCLK changes in falling-edge counts and compares the differences against h. A slave model in the bench presents MISO bits and reads MOSI using the value held just before each edge.

// File: rtl/spi_buf_master.sv
module spi_buf_master #(
  parameter int DEPTH = 200,
  parameter int AW = $clog2(DEPTH),
  parameter int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [7:0]    cfg_data,
  input  logic          start,
  input  logic [3:0]    sel_mask,
  input  logic [LW-1:0] xfer_len,
  input  logic          clr_irq,
  input  logic          buf_we,
  input  logic [AW-1:0] buf_addr,
  input  logic [7:0]    buf_wdata,
  output logic [7:0]    buf_rdata,
  output logic          sclk,
  output logic          mosi,
  input  logic          miso,
  output logic [3:0]    ss_n,
  output logic          irq_n,
  output logic          busy
);

  typedef enum logic [1:0] {S_IDLE, S_LEAD, S_XFER, S_TRAIL} state_t;

  state_t        st;
  logic [7:0]    mem [DEPTH];
  logic [7:0]    cfg, sh, rx, rx_nx, sh_nx, mem_wd;
  logic [6:0]    dcnt, half_m1;
  logic [3:0]    ecnt, mask_q;
  logic [AW-1:0] bidx, last_idx, mem_wa;
  logic          sclk_q, irq_q, mem_we;
  logic          cpol, cpha, lsb_first, tick, edge_now, sample, start_ok;

  assign cpol      = cfg[3];
  assign cpha      = cfg[2];
  assign lsb_first = cfg[5];

  always_comb begin
    case (cfg[1:0])
      2'd0:    half_m1 = 7'd1;
      2'd1:    half_m1 = 7'd7;
      2'd2:    half_m1 = 7'd31;
      default: half_m1 = 7'd63;
    endcase
  end

  assign tick     = (st != S_IDLE) && (dcnt == half_m1);
  assign edge_now = tick && (st == S_LEAD || st == S_XFER);
  assign sample   = (ecnt[0] == cpha);
  assign rx_nx    = lsb_first ? {miso, rx[7:1]} : {rx[6:0], miso};
  assign sh_nx    = lsb_first ? {1'b0, sh[7:1]} : {sh[6:0], 1'b0};
  assign start_ok = start && (st == S_IDLE) && (xfer_len != '0) && (xfer_len <= LW'(DEPTH));

  assign busy      = (st != S_IDLE);
  assign ss_n      = busy ? ~mask_q : 4'hF;
  assign sclk      = sclk_q;
  assign mosi      = lsb_first ? sh[0] : sh[7];
  assign irq_n     = irq_q;
  assign buf_rdata = mem[buf_addr];

  always_comb begin
    mem_we = 1'b0;
    mem_wa = buf_addr;
    mem_wd = buf_wdata;
    if (st == S_IDLE) begin
      mem_we = buf_we;
    end else if (edge_now && ecnt == 4'd15) begin
      mem_we = 1'b1;
      mem_wa = bidx;
      mem_wd = sample ? rx_nx : rx;
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_wa] <= mem_wd;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      st       <= S_IDLE;
      cfg      <= 8'h00;
      sclk_q   <= 1'b0;
      irq_q    <= 1'b1;
      dcnt     <= '0;
      ecnt     <= '0;
      mask_q   <= '0;
      bidx     <= '0;
      last_idx <= '0;
      sh       <= '0;
      rx       <= '0;
    end else begin
      if (clr_irq) irq_q <= 1'b1;
      if (st == S_IDLE) begin
        dcnt <= '0;
        if (cfg_we) begin
          cfg    <= cfg_data;
          sclk_q <= cfg_data[3];
        end
        if (start_ok) begin
          st       <= S_LEAD;
          mask_q   <= sel_mask;
          last_idx <= AW'(xfer_len - 1'b1);
          bidx     <= '0;
          ecnt     <= '0;
          sh       <= mem[0];
          rx       <= '0;
        end
      end else begin
        dcnt <= tick ? '0 : dcnt + 7'd1;
        if (tick && st == S_TRAIL) begin
          st    <= S_IDLE;
          irq_q <= 1'b0;
        end
        if (edge_now) begin
          if (st == S_LEAD) st <= S_XFER;
          sclk_q <= ~sclk_q;
          ecnt   <= ecnt + 4'd1;
          if (sample)                    rx <= rx_nx;
          else if (cpha && ecnt == 4'd0) sh <= mem[bidx];
          else                           sh <= sh_nx;
          if (ecnt == 4'd15) begin
            if (bidx == last_idx) begin
              st <= S_TRAIL;
            end else begin
              bidx <= bidx + 1'b1;
              if (!cpha) sh <= mem[bidx + 1'b1];
            end
          end
        end
      end
    end
  end

  // R10
  sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> sclk == cfg[3]);

  // R5
  lead_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_LEAD) |-> sclk == cpol);

  // R8
  irq_set_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !irq_n);

  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!irq_n && !clr_irq) |=> !irq_n);

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(mask_q));

  // R3
  edge_align_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ecnt == 4'd0);

endmodule

// File: tb/test_spi_buf_master.sv
module test_spi_buf_master;
  localparam int DEPTH = 200;
  localparam int AW = 8;
  localparam int LW = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 1'b0, start = 1'b0, clr_irq = 1'b0, buf_we = 1'b0;
  logic [7:0] cfg_data = '0, buf_wdata = '0;
  logic [3:0] sel_mask = '0;
  logic [LW-1:0] xfer_len = '0;
  logic [AW-1:0] buf_addr = '0;
  logic [7:0] buf_rdata;
  logic sclk, mosi, miso;
  logic [3:0] ss_n;
  logic irq_n, busy;

  always #10 clk = ~clk;

  spi_buf_master #(.DEPTH(DEPTH), .AW(AW), .LW(LW)) i_spi_buf_master (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_data(cfg_data), .start(start),
    .sel_mask(sel_mask), .xfer_len(xfer_len), .clr_irq(clr_irq), .buf_we(buf_we),
    .buf_addr(buf_addr), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata), .sclk(sclk),
    .mosi(mosi), .miso(miso), .ss_n(ss_n), .irq_n(irq_n), .busy(busy));

  int errs = 0, checks = 0;
  int cur_cpha = 0, cur_lsb = 0;
  int cyc = 0, e = 0, t_ss = 0, t_first = 0, t_last = 0, t_end = 0, bcnt = 0;
  logic in_x = 1'b0, ss_chg = 1'b0, sclk_prev = 1'b0, mosi_prev = 1'b0, fin = 1'b0;
  logic [3:0] ss_val = 4'hF;
  logic [7:0] cap [DEPTH];

  localparam logic [19:0] VEC [8] = '{
    {8'h00, 4'h1, 8'd3}, {8'h04, 4'h2, 8'd2}, {8'h08, 4'h4, 8'd2}, {8'h0C, 4'h8, 8'd2},
    {8'h20, 4'h3, 8'd2}, {8'h2D, 4'hF, 8'd1}, {8'hD6, 4'h5, 8'd1}, {8'h23, 4'h9, 8'd2}};

  function automatic logic [7:0] resp(int b);
    return 8'(32'h5A ^ (b * 29));
  endfunction

  function automatic logic [7:0] txd(int i, int s);
    return 8'(i * 7 + s * 13 + 3);
  endfunction

  function automatic int half_of(logic [1:0] r);
    case (r)
      2'd0: return 2;
      2'd1: return 8;
      2'd2: return 32;
      default: return 64;
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // slave model and event monitor, all on the falling edge
  always @(negedge clk) begin
    int w, b, k;
    logic [7:0] rb;
    cyc++;
    if (busy === 1'b1) bcnt++;
    if (ss_n != 4'hF) begin
      if (!in_x) begin in_x = 1'b1; t_ss = cyc; ss_val = ss_n; e = 0; end
      else if (ss_n != ss_val) ss_chg = 1'b1;
      if (sclk !== sclk_prev) begin
        w = e % 16; b = e / 16; k = w / 2;
        if ((w % 2) == cur_cpha && b < DEPTH) cap[b][cur_lsb != 0 ? k : 7 - k] = mosi_prev;
        if (e == 0) t_first = cyc;
        t_last = cyc;
        e++;
      end
    end else if (in_x) begin
      in_x = 1'b0; t_end = cyc;
    end
    w = e % 16; b = e / 16;
    k = (cur_cpha != 0) ? ((w == 0) ? 0 : (w - 1) / 2) : w / 2;
    rb = resp(b);
    miso = rb[cur_lsb != 0 ? k : 7 - k];
    sclk_prev = sclk;
    mosi_prev = mosi;
  end

  task automatic run(input logic [7:0] c, input logic [3:0] m, input int n, input int seed, input int poke);
    int h;
    logic [3:0] mn;
    h = half_of(c[1:0]);
    mn = ~m;
    @(negedge clk); cfg_we = 1'b1; cfg_data = c;
    @(negedge clk); cfg_we = 1'b0;
    cur_cpha = int'(c[2]); cur_lsb = int'(c[5]);
    for (int i = 0; i < n; i++) begin
      buf_we = 1'b1; buf_addr = AW'(i); buf_wdata = txd(i, seed);
      @(negedge clk);
    end
    buf_we = 1'b0;
    clr_irq = 1'b1; @(negedge clk); clr_irq = 1'b0;
    chk("R8 irq_n high after clear", int'(irq_n), 1);
    ss_chg = 1'b0; bcnt = 0;
    start = 1'b1; sel_mask = m; xfer_len = LW'(n);
    @(negedge clk); start = 1'b0;
    if (poke == 1) begin
      repeat (5) @(negedge clk);
      start = 1'b1; sel_mask = ~m; xfer_len = LW'(1);
      @(negedge clk); start = 1'b0;
    end
    if (poke == 2) begin
      repeat (40) @(negedge clk);
      cfg_we = 1'b1; cfg_data = c ^ 8'h0B;
      buf_we = 1'b1; buf_addr = '0; buf_wdata = 8'hEE;
      @(negedge clk); cfg_we = 1'b0; buf_we = 1'b0;
    end
    while (busy === 1'b1) @(negedge clk);
    @(negedge clk);
    chk("R2 R3 busy cycles", bcnt, h * (16 * n + 1));
    chk("R3 sclk edge count", e, 16 * n);
    chk("R5 select lead", t_first - t_ss, h);
    chk("R5 select tail", t_end - t_last, h);
    chk("R4 select mask", int'(ss_val), int'(mn));
    chk("R4 select stable", int'(ss_chg), 0);
    chk("R4 select idle", int'(ss_n), 15);
    chk("R8 irq_n low at end", int'(irq_n), 0);
    chk("R10 sclk idles at cpol", int'(sclk), int'(c[3]));
    for (int i = 0; i < n; i++) begin
      chk("R6 mosi byte", int'(cap[i]), int'(txd(i, seed)));
      buf_addr = AW'(i); #1;
      chk("R7 miso byte in place", int'(buf_rdata), int'(resp(i)));
    end
  endtask

  initial begin
    #4000000;
    if (!fin) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset irq_n", int'(irq_n), 1);
    chk("R1 reset busy", int'(busy), 0);
    chk("R1 reset ss_n", int'(ss_n), 15);
    chk("R1 reset sclk", int'(sclk), 0);

    for (int v = 0; v < 8; v++) begin
      run(VEC[v][19:12], VEC[v][11:8], int'(VEC[v][7:0]), v + 1, 0);
    end

    // R8: stays low without a clear, rises one cycle after clear
    repeat (30) @(negedge clk);
    chk("R8 irq_n held low", int'(irq_n), 0);
    clr_irq = 1'b1; @(negedge clk); clr_irq = 1'b0;
    chk("R8 irq_n cleared", int'(irq_n), 1);

    // R9: out-of-range counts
    start = 1'b1; xfer_len = '0; sel_mask = 4'hF;
    @(negedge clk); start = 1'b0;
    chk("R9 zero count ignored", int'(busy), 0);
    chk("R9 zero count selects", int'(ss_n), 15);
    start = 1'b1; xfer_len = LW'(201);
    @(negedge clk); start = 1'b0;
    chk("R9 oversize count ignored", int'(busy), 0);

    // R9: start while busy; R10: writes while busy
    run(8'h00, 4'h1, 2, 11, 1);
    run(8'h08, 4'hA, 2, 12, 2);

    // full buffer
    run(8'h0C, 4'h6, DEPTH, 13, 0);

    fin = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule